// File: doc/BRIEF.md
# Masked Probe Comparator with Phase Error Latches

This block checks a wide bank of probe lines against expected data and records any disagreement as sticky error flags. The lines are grouped into slices of equal width. For every slice, a small lookup table indexed by the card identifier returns a control word. The control word switches individual comparator channels on or off and assigns the slice to one of two functional error groups, input or output. A pin mask that depends on the same identifier removes unconnected lines from every check.

Two test phases latch errors separately. During the continuity phase, a strobe captures any live mismatch into a continuity flag. During the functional phase, a timing pulse captures mismatches into the input-error or output-error flag, depending on the routing of each slice. A per-channel sticky vector records which lines failed. A live, non-latching mismatch vector is also available. A synchronous clear at the start of each new card test empties all latches.

Top module: `masked_cmp_top`

## Requirements
- R1: After reset, `cont_err`, `func_in_err`, `func_out_err` and every bit of `chan_err` are 0.
- R2: `live_miss[i]` is 1 in the same cycle exactly when line i is enabled, line i is used, and `probe_data[i]` differs from `expect_data[i]`. The output is combinational and never latched.
- R3: Line i belongs to slice s = i/6, channel j = i%6. For card ID c, the control word of slice s has its enable field in bits [5:0] equal to the low 6 bits of ~(c XOR ((7*s) mod 64)). Bit j of the enable field enables channel j; a disabled channel never reports a mismatch. Bit 7 of the word is reserved and is always 0.
- R4: For card ID c, every line with index i >= 72 - 6*c[2:0] is unused and never reports a mismatch or sets any flag.
- R5: A clock edge with `cont_strobe` high, `test_clr` low and any live mismatch sets `cont_err`. The continuity strobe never changes `func_in_err` or `func_out_err`.
- R6: Bit 6 of the control word is the routing bit, equal to c[0] XOR s[0]; 0 selects the input group and 1 selects the output group. A clock edge with `func_pulse` high and `test_clr` low sets `func_in_err` if a slice routed to input has a live mismatch, and sets `func_out_err` if a slice routed to output has one.
- R7: A set flag or `chan_err` bit stays at 1 until `test_clr`, even after the mismatch goes away.
- R8: A clock edge with `test_clr` high clears all latched flags and `chan_err`. The clear takes priority over a strobe or pulse in the same cycle.
- R9: On an edge with either strobe or pulse, and with `test_clr` low, `chan_err` is ORed with `live_miss`.
- R10: Without `cont_strobe`, `func_pulse` or `test_clr`, no latched output changes, whatever the probe data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| card_id | input | 6 | Card identifier; indexes the control tables and the pin mask |
| test_clr | input | 1 | Synchronous clear of all latches at the start of a card test |
| cont_strobe | input | 1 | Continuity-phase capture strobe |
| func_pulse | input | 1 | Functional-phase capture pulse |
| probe_data | input | 72 | Sampled probe lines |
| expect_data | input | 72 | Expected values for the probe lines |
| live_miss | output | 72 | Non-latching qualified mismatch per line |
| chan_err | output | 72 | Sticky per-line error record |
| cont_err | output | 1 | Sticky continuity error |
| func_in_err | output | 1 | Sticky functional error, input group |
| func_out_err | output | 1 | Sticky functional error, output group |

## Verification
The bench uses the default parameters: twelve slices of six channels and a six-bit identifier. With these values every entry of the 64-row tables can be addressed, and the three-bit mask field can mark up to 42 trailing lines as unused. Card IDs 0, 1, 7 and 63 cover a fully used card, both routing polarities, and the largest unused region. With these IDs, the disabled-channel, unused-line and clear-versus-strobe cases can each be set up on a known line.

// File: rtl/masked_cmp_pkg.sv
package masked_cmp_pkg;

    typedef enum logic {
        ROUTE_IN  = 1'b0,
        ROUTE_OUT = 1'b1
    } route_e;

    // key multiplier used to vary the enable pattern per slice
    localparam int SLICE_KEY_MULT = 7;

    // number of card-ID bits that select the unused-pin region
    localparam int MASK_SEL_W = 3;

endpackage

// File: rtl/masked_cmp_ctrl_rom.sv
module masked_cmp_ctrl_rom
    import masked_cmp_pkg::*;
#(
    parameter int SLICE_IDX = 0,
    parameter int CH        = 6,
    parameter int ID_W      = 6
) (
    input  logic [ID_W-1:0] card_id,
    output logic [CH+1:0]   ctrl_word
);
    localparam int DEPTH = 2 ** ID_W;
    localparam int CW    = CH + 2;
    localparam logic [ID_W-1:0] KEY = ID_W'((SLICE_IDX * SLICE_KEY_MULT) % DEPTH);
    localparam logic SLICE_PAR = 1'((SLICE_IDX % 2) == 1);

    logic [CW-1:0] table_w [DEPTH];

    generate
        for (genvar e = 0; e < DEPTH; e++) begin : g_entry
            localparam logic [ID_W-1:0] E = ID_W'(e);
            logic [ID_W-1:0] mix;
            assign mix = ~(E ^ KEY);
            assign table_w[e] = {1'b0, E[0] ^ SLICE_PAR, CH'(mix)};
        end
    endgenerate

    assign ctrl_word = table_w[card_id];

endmodule

// File: rtl/masked_cmp_pin_mask.sv
module masked_cmp_pin_mask
    import masked_cmp_pkg::*;
#(
    parameter int LINES = 72,
    parameter int CH    = 6
) (
    input  logic [MASK_SEL_W-1:0] sel,
    output logic [LINES-1:0]      unused
);
    int used_cnt;

    always_comb begin
        used_cnt = LINES - CH * int'(sel);
        for (int i = 0; i < LINES; i++) begin
            unused[i] = (i >= used_cnt);
        end
    end

endmodule

// File: rtl/masked_cmp_slice.sv
module masked_cmp_slice
    import masked_cmp_pkg::*;
#(
    parameter int CH = 6
) (
    input  logic [CH-1:0] probe,
    input  logic [CH-1:0] expect_v,
    input  logic [CH-1:0] unused,
    input  logic [CH+1:0] ctrl_word,
    output logic [CH-1:0] miss,
    output route_e        route
);
    logic [CH-1:0] en_d;
    logic [CH-1:0] diff_d;

    always_comb begin
        en_d   = ctrl_word[CH-1:0];
        diff_d = probe ^ expect_v;
        miss   = diff_d & en_d & ~unused;
        route  = route_e'(ctrl_word[CH]);
    end

    // reserved control bit must never be set by the table
    always_comb begin
        assert_rsvd_zero_R3: assert (ctrl_word[CH+1] == 1'b0);
    end

endmodule

// File: rtl/masked_cmp_err_latch.sv
module masked_cmp_err_latch
    import masked_cmp_pkg::*;
#(
    parameter int SLICES = 12,
    parameter int CH     = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    cont_stb,
    input  logic                    func_pls,
    input  logic [SLICES*CH-1:0]    miss,
    input  route_e                  route [SLICES],
    output logic [SLICES*CH-1:0]    chan_err,
    output logic                    cont_err,
    output logic                    func_in_err,
    output logic                    func_out_err
);
    localparam int LINES = SLICES * CH;

    typedef struct packed {
        logic             cont;
        logic             fin;
        logic             fout;
        logic [LINES-1:0] ch;
    } latch_t;

    latch_t st_d, st_q;
    logic   hit_any, hit_in, hit_out;

    always_comb begin
        hit_any = |miss;
        hit_in  = 1'b0;
        hit_out = 1'b0;
        for (int s = 0; s < SLICES; s++) begin
            if (route[s] == ROUTE_IN) hit_in  = hit_in  | (|miss[s*CH +: CH]);
            else                      hit_out = hit_out | (|miss[s*CH +: CH]);
        end

        st_d = st_q;
        if (clr) begin
            st_d = '0;
        end else begin
            if (cont_stb) begin
                st_d.cont = st_d.cont | hit_any;
                st_d.ch   = st_d.ch | miss;
            end
            if (func_pls) begin
                st_d.fin  = st_d.fin  | hit_in;
                st_d.fout = st_d.fout | hit_out;
                st_d.ch   = st_d.ch | miss;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cont_err     = st_q.cont;
    assign func_in_err  = st_q.fin;
    assign func_out_err = st_q.fout;
    assign chan_err     = st_q.ch;

    assert_cont_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cont_stb && !clr && hit_any) |=> cont_err);

    assert_func_in_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (func_pls && !clr && hit_in) |=> func_in_err);

    assert_func_out_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (func_pls && !clr && hit_out) |=> func_out_err);

    assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cont_err && !clr) |=> cont_err);

    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!cont_err && !func_in_err && !func_out_err && chan_err == '0));

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !cont_stb && !func_pls) |=> ($stable(chan_err) && $stable(cont_err)
                                              && $stable(func_in_err) && $stable(func_out_err)));

endmodule

// File: rtl/masked_cmp_top.sv
module masked_cmp_top
    import masked_cmp_pkg::*;
#(
    parameter int SLICES = 12,
    parameter int CH     = 6,
    parameter int ID_W   = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ID_W-1:0]      card_id,
    input  logic                 test_clr,
    input  logic                 cont_strobe,
    input  logic                 func_pulse,
    input  logic [SLICES*CH-1:0] probe_data,
    input  logic [SLICES*CH-1:0] expect_data,
    output logic [SLICES*CH-1:0] live_miss,
    output logic [SLICES*CH-1:0] chan_err,
    output logic                 cont_err,
    output logic                 func_in_err,
    output logic                 func_out_err
);
    localparam int LINES = SLICES * CH;

    logic [LINES-1:0] unused_w;
    route_e           route_w [SLICES];

    masked_cmp_pin_mask #(.LINES(LINES), .CH(CH)) u_mask (
        .sel    (card_id[MASK_SEL_W-1:0]),
        .unused (unused_w)
    );

    generate
        for (genvar s = 0; s < SLICES; s++) begin : g_slice
            logic [CH+1:0] ctrl_w;

            masked_cmp_ctrl_rom #(.SLICE_IDX(s), .CH(CH), .ID_W(ID_W)) u_rom (
                .card_id   (card_id),
                .ctrl_word (ctrl_w)
            );

            masked_cmp_slice #(.CH(CH)) u_slice (
                .probe     (probe_data[s*CH +: CH]),
                .expect_v  (expect_data[s*CH +: CH]),
                .unused    (unused_w[s*CH +: CH]),
                .ctrl_word (ctrl_w),
                .miss      (live_miss[s*CH +: CH]),
                .route     (route_w[s])
            );
        end
    endgenerate

    masked_cmp_err_latch #(.SLICES(SLICES), .CH(CH)) u_latch (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr          (test_clr),
        .cont_stb     (cont_strobe),
        .func_pls     (func_pulse),
        .miss         (live_miss),
        .route        (route_w),
        .chan_err     (chan_err),
        .cont_err     (cont_err),
        .func_in_err  (func_in_err),
        .func_out_err (func_out_err)
    );

    // unused lines never show a live mismatch
    always_comb begin
        assert_unused_quiet_R4: assert ((live_miss & unused_w) == '0);
    end

endmodule

// File: tb/masked_cmp_top_tb_top.sv
module masked_cmp_top_tb_top;
    localparam int N = 72;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [5:0]   card_id = '0;
    logic         test_clr = 1'b0;
    logic         cont_strobe = 1'b0;
    logic         func_pulse = 1'b0;
    logic [N-1:0] probe_data = '0;
    logic [N-1:0] expect_data = '0;
    logic [N-1:0] live_miss, chan_err;
    logic         cont_err, func_in_err, func_out_err;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    masked_cmp_top dut_i (
        .clk(clk), .rst_n(rst_n), .card_id(card_id), .test_clr(test_clr),
        .cont_strobe(cont_strobe), .func_pulse(func_pulse),
        .probe_data(probe_data), .expect_data(expect_data),
        .live_miss(live_miss), .chan_err(chan_err), .cont_err(cont_err),
        .func_in_err(func_in_err), .func_out_err(func_out_err)
    );

    // ---------------- model from the requirements ----------------
    function automatic logic line_en(int i, logic [5:0] c);
        logic [5:0] k, en;
        k  = 6'(((i / 6) * 7) % 64);
        en = ~(c ^ k);
        return en[i % 6];
    endfunction

    function automatic logic line_unused(int i, logic [5:0] c);
        return i >= (72 - 6 * int'(c[2:0]));
    endfunction

    function automatic logic slice_route(int s, logic [5:0] c);
        return c[0] ^ 1'((s % 2) == 1);
    endfunction

    function automatic logic [N-1:0] model_live(logic [N-1:0] p, logic [N-1:0] e, logic [5:0] c);
        logic [N-1:0] r;
        for (int i = 0; i < N; i++) r[i] = (p[i] ^ e[i]) & line_en(i, c) & ~line_unused(i, c);
        return r;
    endfunction

    function automatic logic group_hit(logic [N-1:0] lv, logic [5:0] c, logic grp);
        logic h = 1'b0;
        for (int i = 0; i < N; i++) if (lv[i] && slice_route(i / 6, c) == grp) h = 1'b1;
        return h;
    endfunction

    task automatic check(string req, logic [N-1:0] act, logic [N-1:0] exp_v);
        n_chk++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp_v);
        end
    endtask

    task automatic check_flags(string req, logic c, logic fi, logic fo);
        check(req, N'({cont_err, func_in_err, func_out_err}), N'({c, fi, fo}));
    endtask

    task automatic do_clear();
        @(negedge clk); test_clr = 1'b1;
        @(negedge clk); test_clr = 1'b0;
    endtask

    task automatic pulse(bit cont, bit func);
        @(negedge clk); cont_strobe = cont; func_pulse = func;
        @(negedge clk); cont_strobe = 1'b0; func_pulse = 1'b0;
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        check_flags("R1 flags after reset", 1'b0, 1'b0, 1'b0);
        check("R1 chan_err after reset", chan_err, '0);
    endtask

    task automatic t_live();
        logic [5:0] ids [6] = '{6'd0, 6'd1, 6'd7, 6'd42, 6'd63, 6'd21};
        foreach (ids[k]) begin
            for (int r = 0; r < 4; r++) begin
                @(negedge clk);
                card_id = ids[k];
                probe_data  = {$urandom, $urandom, $urandom};
                expect_data = {$urandom, $urandom, $urandom};
                #1 check("R2 live mismatch pattern", live_miss, model_live(probe_data, expect_data, card_id));
            end
        end
        @(negedge clk); expect_data = probe_data;
        #1 check("R2 equal data gives no mismatch", live_miss, '0);
    endtask

    task automatic t_disabled();
        // card 0, slice 1: key 7, enable field 111000 -> channel 0 (line 6) off, channel 3 (line 9) on
        do_clear();
        @(negedge clk); card_id = 6'd0; expect_data = '0; probe_data = '0; probe_data[6] = 1'b1;
        #1 check("R3 disabled channel silent", live_miss, '0);
        pulse(1, 1);
        check_flags("R3 disabled channel sets no flag", 1'b0, 1'b0, 1'b0);
        @(negedge clk); probe_data = '0; probe_data[9] = 1'b1;
        #1 check("R3 enabled channel reports", live_miss, N'(1) << 9);
    endtask

    task automatic t_unused();
        // card 7: lines 30..71 unused; slice 11 key 13, enable ~(7^13)=~10=110101 -> ch 5 (line 71) enabled
        do_clear();
        @(negedge clk); card_id = 6'd7; expect_data = '0; probe_data = '0; probe_data[71] = 1'b1;
        #1 check("R4 unused line silent", live_miss, '0);
        pulse(1, 1);
        check_flags("R4 unused line sets no flag", 1'b0, 1'b0, 1'b0);
        check("R4 unused line chan_err", chan_err, '0);
    endtask

    task automatic t_continuity();
        logic [N-1:0] lv;
        do_clear();
        @(negedge clk); card_id = 6'd0; expect_data = '0; probe_data = '0;
        probe_data[2] = 1'b1; probe_data[10] = 1'b1;
        lv = model_live(probe_data, expect_data, card_id);
        pulse(1, 0);
        check_flags("R5 continuity strobe sets only cont_err", 1'b1, 1'b0, 1'b0);
        check("R9 chan_err after continuity strobe", chan_err, lv);
        @(negedge clk); probe_data = '0;
        repeat (3) @(negedge clk);
        check_flags("R7 flags sticky after mismatch removed", 1'b1, 1'b0, 1'b0);
        check("R7 chan_err sticky", chan_err, lv);
    endtask

    task automatic t_no_strobe();
        do_clear();
        @(negedge clk); card_id = 6'd0; expect_data = '0; probe_data = '1;
        repeat (4) @(negedge clk);
        check_flags("R10 no capture without strobe", 1'b0, 1'b0, 1'b0);
        check("R10 chan_err unchanged without strobe", chan_err, '0);
    endtask

    task automatic t_functional();
        logic [N-1:0] lv;
        // card 0: slice 0 routes to input (line 0), slice 1 routes to output (line 9)
        do_clear();
        @(negedge clk); card_id = 6'd0; expect_data = '0; probe_data = '0; probe_data[0] = 1'b1;
        pulse(0, 1);
        check_flags("R6 input-group mismatch", 1'b0, 1'b1, 1'b0);
        do_clear();
        @(negedge clk); probe_data = '0; probe_data[9] = 1'b1;
        pulse(0, 1);
        check_flags("R6 output-group mismatch", 1'b0, 1'b0, 1'b1);
        // card 1 flips routing; check a mixed pattern against the model
        do_clear();
        @(negedge clk); card_id = 6'd1; expect_data = '0;
        probe_data = {$urandom, $urandom, $urandom};
        lv = model_live(probe_data, expect_data, card_id);
        pulse(0, 1);
        check_flags("R6 routing with card 1", 1'b0, group_hit(lv, 6'd1, 1'b0), group_hit(lv, 6'd1, 1'b1));
        check("R9 chan_err after functional pulse", chan_err, lv);
    endtask

    task automatic t_clear_priority();
        do_clear();
        @(negedge clk); card_id = 6'd0; expect_data = '0; probe_data = '1;
        pulse(1, 1);
        check_flags("R8 setup flags set", 1'b1, 1'b1, 1'b1);
        @(negedge clk); test_clr = 1'b1; cont_strobe = 1'b1; func_pulse = 1'b1;
        @(negedge clk); test_clr = 1'b0; cont_strobe = 1'b0; func_pulse = 1'b0;
        check_flags("R8 clear wins over strobe", 1'b0, 1'b0, 1'b0);
        check("R8 chan_err cleared", chan_err, '0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_live();
        t_disabled();
        t_unused();
        t_continuity();
        t_no_strobe();
        t_functional();
        t_clear_priority();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule